// File: doc/BRIEF.md
# Serial FPGA configuration loader

This block programs a downstream FPGA through a slave-serial style pin set: an active-low PROGRAM output, a configuration clock, a serial data line and a DONE input that reads low while the target is still busy. The configuration image sits in a byte-wide memory with a one-cycle registered read. The host supplies the image length in bytes and pulses `start`. From then on the block works through a full load without further host involvement.

The block scans the image for a sync marker byte of 0xFF. It checks the header byte that follows and assembles the declared payload bit count from the next header bytes, then checks that count against the image length. It pulses PROGRAM, waits for the target to clear its memory, and confirms that DONE reads low. It then clocks the image out from the marker byte to the end, most significant bit first. After a settle interval it confirms that DONE reads high. The result is a level `done` flag or a non-zero error code. Both are held until the next start.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, `busy`, `done`, `cfg_cclk` and `cfg_en` are 0, `cfg_prog_n` is 1 and `err_code` is 0.
- R2: The scan reads bytes from address 0 upward and stops at the first byte equal to 0xFF. If no such byte lies below `img_len`, the load ends with `err_code` 1, and PROGRAM and CCLK stay inactive.
- R3: The byte after the marker must carry 0x2 in bits 7:4. Any other value ends the load with `err_code` 2, and so does a marker that is the last byte of the image.
- R4: The 24-bit payload bit count is built from four header bytes in turn: bits 3:0 of the first header byte form count bits 23:20, the second byte forms bits 19:12, the third byte forms bits 11:4, and bits 7:4 of the fourth byte form bits 3:0. If the marker address plus count/8 is greater than `img_len`, the load ends with `err_code` 3. Equality is accepted.
- R5: `cfg_prog_n` is driven low for at least PROG_CYC cycles. `cfg_en` is high throughout every load, and in particular whenever `cfg_prog_n` is low. `cfg_en` returns to 0 when the block goes idle.
- R6: After the clear wait of CLEAR_CYC cycles, a high `cfg_done` ends the load with `err_code` 4, and no CCLK pulse is issued.
- R7: The data stream starts at the marker byte and covers every byte up to `img_len`-1, each byte most significant bit first. Exactly 8×(`img_len` − marker address) CCLK rising edges are issued.
- R8: Each bit is placed on `cfg_din` while CCLK is low. CCLK then stays high for exactly HI_CYC cycles, and `cfg_din` is held steady for that whole time.
- R9: SETTLE_CYC cycles after the last bit, the block samples `cfg_done`. If it is high, `done` becomes 1 with `err_code` 0. Otherwise `err_code` becomes 5. `done` and a non-zero `err_code` never appear together.
- R10: `done` and `err_code` hold their values while the block is idle, and both are cleared by the next start. A start pulse during a load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin a load |
| img_len | input | ADDR_W+1 | Image length in bytes, captured at start |
| mem_rd | output | 1 | Read strobe to the image memory |
| mem_addr | output | ADDR_W | Byte address to the image memory |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| cfg_prog_n | output | 1 | Active-low PROGRAM pin |
| cfg_cclk | output | 1 | Configuration clock pin |
| cfg_din | output | 1 | Serial configuration data pin |
| cfg_en | output | 1 | Enable/select for the configuration pins, high during a load |
| cfg_done | input | 1 | DONE pin from the target, low while busy |
| busy | output | 1 | Load in progress |
| done | output | 1 | Last load succeeded |
| err_code | output | 3 | 0 none, 1 no marker, 2 bad header, 3 image too short, 4 clear not acknowledged, 5 DONE never set |

## Verification
The hardest situation to create from the ports is a failure after streaming. The target has to acknowledge the memory clear by pulling DONE low and then never raise it, so the block must pass every earlier gate and clock out the whole image before it reports code 5. The bench drives `cfg_done` from a small target model with three behaviours: normal, stuck high and stuck low. In the normal behaviour, the model raises DONE only after it has counted exactly the expected number of CCLK edges. A length check that is off by one byte, or a dropped bit, then surfaces as a timeout in DONE rather than passing unnoticed. Header images place the count nibbles so that a misplaced nibble changes the length verdict, and one vector sits exactly at the accepted boundary.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  localparam int unsigned CNT_W = 24;
  localparam logic [7:0] SYNC_BYTE = 8'hFF;
  localparam logic [3:0] HDR_TAG = 4'h2;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_NO_HDR   = 3'd1,
    ERR_BAD_HDR  = 3'd2,
    ERR_SHORT    = 3'd3,
    ERR_NO_CLR   = 3'd4,
    ERR_NOT_DONE = 3'd5
  } cfgl_err_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SCAN_REQ,
    S_SCAN_DAT,
    S_HDR_REQ,
    S_HDR_DAT,
    S_LEN_CHK,
    S_PROG,
    S_CLEAR,
    S_CHK_CLR,
    S_STR_REQ,
    S_STR_DAT,
    S_STR_SHIFT,
    S_SETTLE,
    S_FINAL
  } cfgl_state_e;

endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;

endmodule

// File: rtl/cfgl_timer.sv
module cfgl_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          zero
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

  AST_TIMER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5

endmodule

// File: rtl/cfgl_shift.sv
module cfgl_shift #(
  parameter int unsigned LO_CYC = 1,
  parameter int unsigned HI_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] data,
  output logic       busy,
  output logic       cclk,
  output logic       din
);

  localparam int unsigned PMAX = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int unsigned PW   = (PMAX > 1) ? $clog2(PMAX) : 1;
  localparam logic [PW-1:0] LO_RLD = PW'(LO_CYC - 1);
  localparam logic [PW-1:0] HI_RLD = PW'(HI_CYC - 1);

  logic [7:0]    sh_q, sh_d;
  logic [2:0]    bit_q, bit_d;
  logic [PW-1:0] pc_q, pc_d;
  logic          hi_q, hi_d;
  logic          act_q, act_d;

  always_comb begin
    sh_d  = sh_q;
    bit_d = bit_q;
    pc_d  = pc_q;
    hi_d  = hi_q;
    act_d = act_q;
    if (load) begin
      sh_d  = data;
      bit_d = 3'd7;
      pc_d  = LO_RLD;
      hi_d  = 1'b0;
      act_d = 1'b1;
    end else if (act_q) begin
      if (pc_q != '0) begin
        pc_d = pc_q - 1'b1;
      end else if (!hi_q) begin
        hi_d = 1'b1;
        pc_d = HI_RLD;
      end else begin
        hi_d = 1'b0;
        if (bit_q == 3'd0) begin
          act_d = 1'b0;
        end else begin
          sh_d  = {sh_q[6:0], 1'b0};
          bit_d = bit_q - 1'b1;
          pc_d  = LO_RLD;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= '0;
      pc_q  <= '0;
      hi_q  <= 1'b0;
      act_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      bit_q <= bit_d;
      pc_q  <= pc_d;
      hi_q  <= hi_d;
      act_q <= act_d;
    end
  end

  assign busy = act_q;
  assign cclk = act_q & hi_q;
  assign din  = sh_q[7];

  AST_DIN_STEADY_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk && $past(cclk)) |-> $stable(din)); // R8
  AST_CCLK_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk) |-> $past(act_q)); // R8

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfgl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PROG_CYC   = 4,
  parameter int unsigned CLEAR_CYC  = 50,
  parameter int unsigned SETTLE_CYC = 100,
  parameter int unsigned LO_CYC     = 1,
  parameter int unsigned HI_CYC     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W:0]   img_len,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              cfg_prog_n,
  output logic              cfg_cclk,
  output logic              cfg_din,
  output logic              cfg_en,
  input  logic              cfg_done,
  output logic              busy,
  output logic              done,
  output logic [2:0]        err_code
);

  localparam int unsigned LEN_W = ADDR_W + 1;
  localparam int unsigned SW    = ((LEN_W > CNT_W) ? LEN_W : CNT_W) + 1;
  localparam int unsigned TMAX0 = (PROG_CYC > CLEAR_CYC) ? PROG_CYC : CLEAR_CYC;
  localparam int unsigned TMAX  = (TMAX0 > SETTLE_CYC) ? TMAX0 : SETTLE_CYC;
  localparam int unsigned TW    = $clog2(TMAX + 1);

  // reset: asynchronous assert, synchronous release
  logic rs1_q, rs2_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign srst_n = rs2_q;

  cfgl_state_e      state_q, state_d;
  logic [LEN_W-1:0] ptr_q, ptr_d;
  logic [LEN_W-1:0] mark_q, mark_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       hidx_q, hidx_d;
  cfgl_err_e        err_q, err_d;
  logic             done_q, done_d;
  logic             prog_n_q, en_q;

  logic             tmr_load, tmr_zero;
  logic [TW-1:0]    tmr_val;
  logic             sh_load, sh_busy;
  logic             done_s;
  logic             rd;
  logic [SW-1:0]    end_pos;

  cfgl_sync u_done_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d     (cfg_done),
    .q     (done_s)
  );

  cfgl_timer #(.TW(TW)) u_timer (
    .clk   (clk),
    .rst_n (srst_n),
    .load  (tmr_load),
    .val   (tmr_val),
    .zero  (tmr_zero)
  );

  cfgl_shift #(.LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) u_shift (
    .clk   (clk),
    .rst_n (srst_n),
    .load  (sh_load),
    .data  (mem_rdata),
    .busy  (sh_busy),
    .cclk  (cfg_cclk),
    .din   (cfg_din)
  );

  assign end_pos = SW'(mark_q) + SW'(cnt_q >> 3);

  always_comb begin
    state_d  = state_q;
    ptr_d    = ptr_q;
    mark_d   = mark_q;
    len_d    = len_q;
    cnt_d    = cnt_q;
    hidx_d   = hidx_q;
    err_d    = err_q;
    done_d   = done_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    rd       = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          ptr_d   = '0;
          len_d   = img_len;
          err_d   = ERR_NONE;
          done_d  = 1'b0;
          state_d = S_SCAN_REQ;
        end
      end
      S_SCAN_REQ: begin
        if (ptr_q >= len_q) begin
          err_d   = ERR_NO_HDR;
          state_d = S_IDLE;
        end else begin
          rd      = 1'b1;
          state_d = S_SCAN_DAT;
        end
      end
      S_SCAN_DAT: begin
        ptr_d = ptr_q + 1'b1;
        if (mem_rdata == SYNC_BYTE) begin
          mark_d  = ptr_q;
          hidx_d  = 2'd0;
          state_d = S_HDR_REQ;
        end else begin
          state_d = S_SCAN_REQ;
        end
      end
      S_HDR_REQ: begin
        if (hidx_q == 2'd0 && ptr_q >= len_q) begin
          err_d   = ERR_BAD_HDR;
          state_d = S_IDLE;
        end else begin
          rd      = 1'b1;
          state_d = S_HDR_DAT;
        end
      end
      S_HDR_DAT: begin
        ptr_d   = ptr_q + 1'b1;
        hidx_d  = hidx_q + 1'b1;
        state_d = (hidx_q == 2'd3) ? S_LEN_CHK : S_HDR_REQ;
        unique case (hidx_q)
          2'd0: begin
            if (mem_rdata[7:4] != HDR_TAG) begin
              err_d   = ERR_BAD_HDR;
              state_d = S_IDLE;
            end
            cnt_d[23:20] = mem_rdata[3:0];
          end
          2'd1: cnt_d[19:12] = mem_rdata;
          2'd2: cnt_d[11:4]  = mem_rdata;
          default: cnt_d[3:0] = mem_rdata[7:4];
        endcase
      end
      S_LEN_CHK: begin
        if (end_pos > SW'(len_q)) begin
          err_d   = ERR_SHORT;
          state_d = S_IDLE;
        end else begin
          tmr_load = 1'b1;
          tmr_val  = TW'(PROG_CYC);
          state_d  = S_PROG;
        end
      end
      S_PROG: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(CLEAR_CYC);
          state_d  = S_CLEAR;
        end
      end
      S_CLEAR: begin
        if (tmr_zero) state_d = S_CHK_CLR;
      end
      S_CHK_CLR: begin
        if (done_s) begin
          err_d   = ERR_NO_CLR;
          state_d = S_IDLE;
        end else begin
          ptr_d   = mark_q;
          state_d = S_STR_REQ;
        end
      end
      S_STR_REQ: begin
        if (ptr_q >= len_q) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(SETTLE_CYC);
          state_d  = S_SETTLE;
        end else begin
          rd      = 1'b1;
          state_d = S_STR_DAT;
        end
      end
      S_STR_DAT: begin
        sh_load = 1'b1;
        ptr_d   = ptr_q + 1'b1;
        state_d = S_STR_SHIFT;
      end
      S_STR_SHIFT: begin
        if (!sh_busy) state_d = S_STR_REQ;
      end
      S_SETTLE: begin
        if (tmr_zero) state_d = S_FINAL;
      end
      S_FINAL: begin
        if (done_s) done_d = 1'b1;
        else        err_d  = ERR_NOT_DONE;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q  <= S_IDLE;
      ptr_q    <= '0;
      mark_q   <= '0;
      len_q    <= '0;
      cnt_q    <= '0;
      hidx_q   <= '0;
      err_q    <= ERR_NONE;
      done_q   <= 1'b0;
      prog_n_q <= 1'b1;
      en_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      ptr_q    <= ptr_d;
      mark_q   <= mark_d;
      len_q    <= len_d;
      cnt_q    <= cnt_d;
      hidx_q   <= hidx_d;
      err_q    <= err_d;
      done_q   <= done_d;
      prog_n_q <= (state_d != S_PROG);
      en_q     <= (state_d != S_IDLE);
    end
  end

  assign mem_rd     = rd;
  assign mem_addr   = ptr_q[ADDR_W-1:0];
  assign cfg_prog_n = prog_n_q;
  assign cfg_en     = en_q;
  assign busy       = (state_q != S_IDLE);
  assign done       = done_q;
  assign err_code   = err_q;

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == S_IDLE && !start) |=> ($stable(err_code) && $stable(done))); // R10
  AST_PROG_IN_LOAD: assert property (@(posedge clk) disable iff (!srst_n)
    !cfg_prog_n |-> cfg_en); // R5
  AST_CCLK_IN_STREAM: assert property (@(posedge clk) disable iff (!srst_n)
    cfg_cclk |-> (state_q == S_STR_SHIFT)); // R7
  AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!srst_n)
    sh_load |-> !sh_busy); // R7
  AST_DONE_XOR_ERR: assert property (@(posedge clk) disable iff (!srst_n)
    !(done && err_code != 3'd0)); // R9

endmodule

// File: tb/cfg_serial_loader_bench.sv
`timescale 1ns/1ps
module cfg_serial_loader_bench;

  localparam int PROG_CYC = 4;
  localparam int HI_CYC   = 2;

  typedef struct packed {
    logic [7:0]  mpos;   // 8'hFF: no marker
    logic [3:0]  tag;
    logic [23:0] cnt;
    logic [8:0]  len;
    logic [1:0]  mode;   // 0 normal, 1 DONE stuck high, 2 DONE stuck low
    logic [2:0]  exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [0:NV-1] = '{
    '{8'd0,   4'h2, 24'd128,     9'd16, 2'd0, 3'd0},
    '{8'd3,   4'h2, 24'd80,      9'd13, 2'd0, 3'd0},
    '{8'd2,   4'h2, 24'd72,      9'd10, 2'd0, 3'd3},
    '{8'hFF,  4'h2, 24'd8,       9'd8,  2'd0, 3'd1},
    '{8'd1,   4'h3, 24'd8,       9'd12, 2'd0, 3'd2},
    '{8'd0,   4'h2, 24'd64,      9'd10, 2'd1, 3'd4},
    '{8'd0,   4'h2, 24'd64,      9'd10, 2'd2, 3'd5},
    '{8'd5,   4'h2, 24'h100000,  9'd12, 2'd0, 3'd3},
    '{8'd7,   4'h2, 24'd8,       9'd8,  2'd0, 3'd2},
    '{8'd0,   4'h2, 24'h00004F,  9'd9,  2'd0, 3'd0}
  };

  logic        clk, rst_n, start;
  logic [16:0] img_len;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        cfg_prog_n, cfg_cclk, cfg_din, cfg_en, cfg_done;
  logic        busy, done;
  logic [2:0]  err_code;

  cfg_serial_loader u_cfg_serial_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .cfg_prog_n(cfg_prog_n), .cfg_cclk(cfg_cclk), .cfg_din(cfg_din),
    .cfg_en(cfg_en), .cfg_done(cfg_done), .busy(busy), .done(done),
    .err_code(err_code)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] img [0:255];
  logic       cap [0:1023];
  int cap_n, exp_bits, prog_lo, en_bad, hi_bad, din_bad, hi_len, cyc;
  int checks, errors;
  logic [1:0] mode;
  logic prev_cclk, prev_din;

  always @(posedge clk) if (mem_rd) mem_rdata <= img[mem_addr[7:0]];

  always @(posedge cfg_cclk) begin
    if (cap_n < 1024) cap[cap_n] = cfg_din;
    cap_n = cap_n + 1;
  end

  always @(posedge clk) begin
    case (mode)
      2'd1: cfg_done <= 1'b1;
      2'd2: cfg_done <= 1'b0;
      default: begin
        if (!cfg_prog_n) cfg_done <= 1'b0;
        else if (exp_bits != 0 && cap_n == exp_bits) cfg_done <= 1'b1;
      end
    endcase
  end

  always @(posedge clk) begin
    if (!cfg_prog_n) prog_lo = prog_lo + 1;
    if (!cfg_prog_n && !cfg_en) en_bad = en_bad + 1;
    if (cfg_cclk && prev_cclk && cfg_din != prev_din) din_bad = din_bad + 1;
    if (cfg_cclk) hi_len = hi_len + 1;
    else if (prev_cclk) begin
      if (hi_len != HI_CYC) hi_bad = hi_bad + 1;
      hi_len = 0;
    end
    prev_cclk = cfg_cclk;
    prev_din  = cfg_din;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic build(input vec_t v);
    for (int i = 0; i < 256; i++) begin
      if (v.mpos == 8'hFF || i < int'(v.mpos)) img[i] = 8'h5A;
      else if (i == int'(v.mpos))     img[i] = 8'hFF;
      else if (i == int'(v.mpos) + 1) img[i] = {v.tag, v.cnt[23:20]};
      else if (i == int'(v.mpos) + 2) img[i] = v.cnt[19:12];
      else if (i == int'(v.mpos) + 3) img[i] = v.cnt[11:4];
      else if (i == int'(v.mpos) + 4) img[i] = {v.cnt[3:0], 4'h9};
      else img[i] = 8'(i * 29 + 3);
    end
    img_len  = 17'(v.len);
    mode     = v.mode;
    exp_bits = (v.exp == 3'd0 || v.exp == 3'd5) ? 8 * (int'(v.len) - int'(v.mpos)) : 0;
    cap_n = 0; prog_lo = 0; en_bad = 0; hi_bad = 0; din_bad = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic check_vec(input vec_t v, input int idx);
    int bad;
    bad = 0;
    chk(err_code == v.exp, $sformatf("R2/R3/R4/R6/R9 vec%0d err_code", idx), err_code, v.exp);
    chk(done == (v.exp == 3'd0), $sformatf("R9 vec%0d done", idx), done, v.exp == 3'd0);
    chk(cap_n == exp_bits, $sformatf("R7 vec%0d cclk edges", idx), cap_n, exp_bits);
    for (int k = 0; k < exp_bits && k < cap_n; k++)
      if (cap[k] != img[int'(v.mpos) + k / 8][7 - k % 8]) bad++;
    chk(bad == 0, $sformatf("R7 vec%0d bit order", idx), bad, 0);
    if (v.exp == 3'd0 || v.exp >= 3'd4)
      chk(prog_lo >= PROG_CYC, $sformatf("R5 vec%0d prog pulse", idx), prog_lo, PROG_CYC);
    else
      chk(prog_lo == 0, $sformatf("R2 vec%0d no prog", idx), prog_lo, 0);
    chk(en_bad == 0 && cfg_en == 1'b0, $sformatf("R5 vec%0d enable", idx), en_bad, 0);
    chk(hi_bad == 0, $sformatf("R8 vec%0d cclk high length", idx), hi_bad, 0);
    chk(din_bad == 0, $sformatf("R8 vec%0d din steady", idx), din_bad, 0);
  endtask

  initial begin
    checks = 0; errors = 0; cyc = 0; cap_n = 0; exp_bits = 0;
    prog_lo = 0; en_bad = 0; hi_bad = 0; din_bad = 0; hi_len = 0;
    prev_cclk = 1'b0; prev_din = 1'b0; mode = 2'd0; cfg_done = 1'b0;
    rst_n = 1'b0; start = 1'b0; img_len = '0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !cfg_cclk && !cfg_en && cfg_prog_n && err_code == 3'd0,
        "R1 reset outputs", {busy, done, cfg_cclk, cfg_en, cfg_prog_n}, 5'b00001);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && err_code == 3'd0 && cfg_prog_n, "R1 after release", busy, 0);

    // table walk
    for (int n = 0; n < NV; n++) begin
      build(VECS[n]);
      pulse_start();
      wait_idle();
      repeat (2) @(negedge clk);
      check_vec(VECS[n], n);
    end

    // R10: error code held while idle, cleared by start
    build(VECS[3]);
    pulse_start();
    wait_idle();
    repeat (30) @(negedge clk);
    chk(err_code == 3'd1 && !done, "R10 code held idle", err_code, 1);
    build(VECS[0]);
    pulse_start();
    chk(busy && err_code == 3'd0, "R10 start clears code", err_code, 0);

    // R10: start during a load is ignored
    repeat (60) @(negedge clk);
    chk(busy, "R10 mid-load busy", busy, 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_idle();
    repeat (2) @(negedge clk);
    chk(done && err_code == 3'd0, "R10 restart ignored result", err_code, 0);
    chk(cap_n == 128, "R10 restart ignored edge count", cap_n, 128);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule